// File: doc/BRIEF.md
# Peripheral Bus Error and Timeout Monitor

The monitor sits between a CPU-side request port and a peripheral register bus and supervises every register access that crosses it. A requester raises a request and holds its address, direction and write data steady until it receives a one-cycle response. The monitor forwards the access to the peripheral bus. It ends the access with an error response in two cases: the access falls inside one of three monitored I/O windows and no peripheral claims the address, or the addressed peripheral stays silent for a fixed budget of cycles.

Three local registers live inside the monitor and are answered directly. A configuration register holds the bus-error enable. A separate timeout-control register holds the timeout enable. A read-only status register keeps sticky error flags, and reading it clears them. While the idle input is high, the monitor accepts nothing. A request that arrives during idle waits unanswered until idle falls.

Top module: `periph_err_monitor`

## Requirements
- R1: After reset the configuration register reads 0x8000, the status register reads 0x0000 and the timeout-control register reads 0x0000. No response and no peripheral request are active.
- R2: A bus error is raised when all three of these hold: the bus-error enable is 1, the address lies in 0x0000–0x03FF, 0x1400–0x17FF or 0x2000–0x23FF, and per_sel_i is low. The error response comes one cycle after acceptance, and no peripheral request is issued. An address outside these windows is never reported as a bus error and is always forwarded.
- R3: The configuration register sits at 0x0100, and its bit 15 is the read/write bus-error enable. The timeout-control register sits at 0x0104, and its bit 0 is the read/write timeout enable. All other bits of both registers read 0 and ignore writes. Local registers answer one cycle after acceptance and ignore per_sel_i.
- R4: The status register sits at 0x0102 and is read-only. Bit 15 flags an invalid window access, bit 12 flags a timeout, bit 4 flags a failing write and bit 3 flags a failing read. All other bits read 0, and writes to the register change nothing.
- R5: Status flags are sticky. A read of the status register returns the flags as they stood before the read and then clears them all.
- R6: With the timeout enable set, a forwarded access that receives no per_ack_i during 512 cycles of peripheral request ends with an error response 513 cycles after acceptance. An acknowledge in the 512th cycle still completes the access normally.
- R7: With the bus-error enable cleared, an invalid window access is forwarded like any other access. If it also has no acknowledge and the timeout enable is 0, it never receives a response.
- R8: An error response has rsp_err_o = 1 and rsp_rdata_o = 0. A successful read returns per_rdata_i. A successful write returns data 0. A forwarded access responds in the cycle after per_ack_i.
- R9: While idle_i is high, no request is accepted: no peripheral request and no response appear. A request held across idle is served once idle_i falls.
- R10: Each response is a pulse of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idle_i | input | 1 | Idle: stop accepting and checking requests |
| req_valid_i | input | 1 | Request pending, held until the response |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Register address |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_err_o | output | 1 | Response is an error; read data invalid |
| rsp_rdata_o | output | 16 | Read data |
| per_req_o | output | 1 | Access active on the peripheral bus |
| per_write_o | output | 1 | Peripheral access direction |
| per_addr_o | output | 16 | Peripheral address |
| per_wdata_o | output | 16 | Peripheral write data |
| per_sel_i | input | 1 | Some peripheral decodes the presented address |
| per_ack_i | input | 1 | Peripheral completes the access |
| per_rdata_i | input | 16 | Peripheral read data |

## Verification
The bench probes the first and last address of every window and the addresses just outside them. An off-by-one window decode would either report a bus error on an address outside the windows or forward an unclaimed address that should fail. It acknowledges an access in exactly the 512th waiting cycle and also lets an access run past it. An off-by-one counter would then fail a valid access or answer one cycle late. It reads the status register twice in a row, which exposes flags that do not clear or that clear before they are returned. It holds a request across idle and checks that an invalid access with the enable cleared hangs rather than failing.

// File: rtl/periph_err_monitor.sv
module periph_err_monitor #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int TIMEOUT = 512,
  parameter int NWIN = 3,
  parameter int WIN_BITS = 10,
  parameter logic [NWIN*AW-1:0] WIN_BASE = {16'h2000, 16'h1400, 16'h0000},
  parameter logic [AW-1:0] CFG_ADDR = 16'h0100,
  parameter logic [AW-1:0] STS_ADDR = 16'h0102,
  parameter logic [AW-1:0] TOC_ADDR = 16'h0104,
  parameter int EN_BIT = 15,
  parameter int INV_BIT = 15,
  parameter int TO_BIT = 12,
  parameter int WR_BIT = 4,
  parameter int RD_BIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle_i,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          per_req_o,
  output logic          per_write_o,
  output logic [AW-1:0] per_addr_o,
  output logic [DW-1:0] per_wdata_o,
  input  logic          per_sel_i,
  input  logic          per_ack_i,
  input  logic [DW-1:0] per_rdata_i
);
  localparam int CW = $clog2(TIMEOUT);

  typedef enum logic [1:0] {S_FREE, S_WAIT, S_RSP} state_t;

  state_t        st;
  logic          err_en, to_en;
  logic [DW-1:0] sts, sts_set, loc_rdata, rdata_q;
  logic [CW-1:0] cnt;
  logic          err_q;
  logic [NWIN-1:0] win_hit;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    assign win_hit[i] = req_addr_i[AW-1:WIN_BITS] == WIN_BASE[i*AW+WIN_BITS +: AW-WIN_BITS];
  end

  wire is_cfg = req_addr_i == CFG_ADDR;
  wire is_sts = req_addr_i == STS_ADDR;
  wire is_toc = req_addr_i == TOC_ADDR;
  wire is_loc = is_cfg | is_sts | is_toc;

  wire accept = (st == S_FREE) && req_valid_i && !idle_i;
  wire bad    = accept && !is_loc && (|win_hit) && !per_sel_i && err_en;
  wire tmo    = (st == S_WAIT) && !per_ack_i && to_en && (cnt == CW'(TIMEOUT - 1));
  wire fail   = bad | tmo;
  wire sts_rd = accept && is_sts && !req_write_i;

  assign sts_set = fail ? ((DW'(bad) << INV_BIT) | (DW'(tmo) << TO_BIT) |
                           (DW'(1) << (req_write_i ? WR_BIT : RD_BIT))) : '0;

  assign loc_rdata = is_cfg ? (DW'(err_en) << EN_BIT) :
                     is_sts ? sts :
                     is_toc ? DW'(to_en) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else if (sts_rd) sts <= '0;
    else sts <= sts | sts_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_FREE;
      err_en  <= 1'b1;
      to_en   <= 1'b0;
      cnt     <= '0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      case (st)
        S_FREE: if (accept) begin
          if (is_loc) begin
            st      <= S_RSP;
            err_q   <= 1'b0;
            rdata_q <= req_write_i ? '0 : loc_rdata;
            if (req_write_i && is_cfg) err_en <= req_wdata_i[EN_BIT];
            if (req_write_i && is_toc) to_en  <= req_wdata_i[0];
          end else if (bad) begin
            st      <= S_RSP;
            err_q   <= 1'b1;
            rdata_q <= '0;
          end else begin
            st  <= S_WAIT;
            cnt <= '0;
          end
        end
        S_WAIT: begin
          cnt <= cnt + 1'b1;
          if (per_ack_i) begin
            st      <= S_RSP;
            err_q   <= 1'b0;
            rdata_q <= req_write_i ? '0 : per_rdata_i;
          end else if (tmo) begin
            st      <= S_RSP;
            err_q   <= 1'b1;
            rdata_q <= '0;
          end
        end
        default: st <= S_FREE;
      endcase
    end
  end

  assign rsp_valid_o = st == S_RSP;
  assign rsp_err_o   = err_q;
  assign rsp_rdata_o = rdata_q;
  assign per_req_o   = st == S_WAIT;
  assign per_write_o = req_write_i;
  assign per_addr_o  = req_addr_i;
  assign per_wdata_o = req_wdata_i;
endmodule

module periph_err_monitor_chk #(
  parameter int DW = 16,
  parameter int TIMEOUT = 512
) (
  input logic          clk,
  input logic          rst_n,
  input logic          idle_i,
  input logic          rsp_valid_o,
  input logic          rsp_err_o,
  input logic [DW-1:0] rsp_rdata_o,
  input logic          per_req_o,
  input logic          per_ack_i,
  input logic          to_en,
  input logic          sts_rd,
  input logic [DW-1:0] sts
);
  localparam int WW = $clog2(TIMEOUT) + 2;
  logic [WW-1:0] wc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wc <= '0;
    else if (per_req_o && !per_ack_i) wc <= (wc == {WW{1'b1}}) ? wc : wc + 1'b1;
    else wc <= '0;
  end

  a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o);
  a_r8_err_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && rsp_err_o |-> rsp_rdata_o == '0);
  a_r9_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    idle_i && !per_req_o |=> !per_req_o);
  a_r9_idle_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    idle_i && !per_req_o && !rsp_valid_o |=> !rsp_valid_o);
  a_r6_timeout_bound: assert property (@(posedge clk) disable iff (!rst_n)
    to_en && wc >= WW'(TIMEOUT) |-> !per_req_o);
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_rd |=> (sts & $past(sts)) == $past(sts));
endmodule

bind periph_err_monitor periph_err_monitor_chk #(.DW(DW), .TIMEOUT(TIMEOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .rsp_valid_o(rsp_valid_o),
  .rsp_err_o(rsp_err_o), .rsp_rdata_o(rsp_rdata_o), .per_req_o(per_req_o),
  .per_ack_i(per_ack_i), .to_en(to_en), .sts_rd(sts_rd), .sts(sts));

// File: tb/periph_err_monitor_tb.sv
module periph_err_monitor_tb;
  logic clk = 0, rst_n = 0, idle = 0;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic rsp_valid, rsp_err, per_req, per_write, per_sel = 0, per_ack = 0;
  logic [15:0] rsp_rdata, per_addr, per_wdata, per_rdata;
  int checks = 0, errors = 0;
  int pw = 0, p_delay = 0;
  bit m_en = 1, m_to = 0;
  logic [15:0] m_sts = 0;

  always #5 clk = ~clk;

  periph_err_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .idle_i(idle), .req_valid_i(req_valid),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .per_req_o(per_req), .per_write_o(per_write), .per_addr_o(per_addr),
    .per_wdata_o(per_wdata), .per_sel_i(per_sel), .per_ack_i(per_ack),
    .per_rdata_i(per_rdata));

  assign per_rdata = per_addr ^ 16'h5A3C;

  always @(negedge clk) begin
    if (per_req) begin pw = pw + 1; per_ack = (pw == p_delay); end
    else begin pw = 0; per_ack = 0; end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req_valid = 0; idle = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_en = 1; m_to = 0; m_sts = 0;
  endtask

  function automatic bit in_win(logic [15:0] a);
    return a < 16'h0400 || (a >= 16'h1400 && a < 16'h1800) || (a >= 16'h2000 && a < 16'h2400);
  endfunction

  function automatic bit is_loc(logic [15:0] a);
    return a == 16'h0100 || a == 16'h0102 || a == 16'h0104;
  endfunction

  task automatic acc(input bit w, input logic [15:0] a, input logic [15:0] wd,
                     input bit sel, input int dly, input string tag);
    int lat = 0, elat; bit got = 0, saw = 0, eerr = 0, expfwd = 0;
    logic [15:0] data = 0, edata = 0;
    logic [15:0] rwb = w ? 16'h0010 : 16'h0008;
    bit err = 0;
    if (is_loc(a)) begin
      elat = 1;
      if (!w) edata = (a == 16'h0100) ? {m_en, 15'b0} : (a == 16'h0102) ? m_sts : {15'b0, m_to};
      if (w && a == 16'h0100) m_en = wd[15];
      if (w && a == 16'h0104) m_to = wd[0];
      if (!w && a == 16'h0102) m_sts = 0;
    end else if (in_win(a) && !sel && m_en) begin
      elat = 1; eerr = 1; m_sts |= 16'h8000 | rwb;
    end else begin
      expfwd = 1;
      if (dly >= 1 && dly <= 512) begin elat = dly + 1; edata = w ? 16'h0 : a ^ 16'h5A3C; end
      else if (m_to) begin elat = 513; eerr = 1; m_sts |= 16'h1000 | rwb; end
      else elat = -1;
    end
    @(negedge clk);
    p_delay = dly; per_sel = sel;
    req_valid = 1; req_write = w; req_addr = a; req_wdata = wd;
    while (!got && lat < 600) begin
      @(negedge clk); lat++;
      if (per_req) saw = 1;
      if (rsp_valid) begin got = 1; err = rsp_err; data = rsp_rdata; end
    end
    req_valid = 0;
    if (elat < 0) begin
      chk(!got, tag, "hung access responded", int'(got), 0);
      chk(saw, tag, "hung access forwarded", int'(saw), 1);
    end else begin
      chk(got && lat == elat, tag, "response latency", lat, elat);
      chk(err == eerr, tag, "error flag", int'(err), int'(eerr));
      chk(data == edata, tag, "response data", int'(data), int'(edata));
      chk(saw == expfwd, tag, "peripheral request", int'(saw), int'(expfwd));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    do_reset();
    @(negedge clk);
    chk(!rsp_valid && !per_req, "R1", "idle outputs after reset", int'({rsp_valid, per_req}), 0);
    acc(0, 16'h0100, 0, 0, 0, "R1");
    acc(0, 16'h0102, 0, 0, 0, "R1");
    acc(0, 16'h0104, 0, 0, 0, "R1");
    // R3: reserved bits, enable bits
    acc(1, 16'h0100, 16'hFFFF, 0, 0, "R3"); acc(0, 16'h0100, 0, 0, 0, "R3");
    acc(1, 16'h0100, 16'h7FFF, 0, 0, "R3"); acc(0, 16'h0100, 0, 0, 0, "R3");
    acc(1, 16'h0100, 16'h8000, 0, 0, "R3");
    acc(1, 16'h0104, 16'hFFFF, 0, 0, "R3"); acc(0, 16'h0104, 0, 1, 0, "R3");
    acc(1, 16'h0104, 16'h0000, 0, 0, "R3");
    // R4: read-only status
    acc(1, 16'h0102, 16'hFFFF, 0, 0, "R4"); acc(0, 16'h0102, 0, 0, 0, "R4");
    // R2 window edges, R5 sticky clear
    acc(0, 16'h0123, 0, 0, 3, "R2"); acc(0, 16'h0102, 0, 0, 0, "R5"); acc(0, 16'h0102, 0, 0, 0, "R5");
    acc(1, 16'h17FF, 16'h1234, 0, 3, "R2"); acc(0, 16'h0102, 0, 0, 0, "R4");
    acc(0, 16'h03FF, 0, 0, 2, "R2"); acc(0, 16'h0400, 0, 0, 2, "R2");
    acc(0, 16'h13FF, 0, 0, 2, "R2"); acc(1, 16'h1400, 16'h5, 0, 2, "R2");
    acc(0, 16'h23FF, 0, 0, 2, "R2"); acc(0, 16'h2400, 0, 0, 2, "R2");
    acc(0, 16'h0000, 0, 1, 4, "R8"); acc(1, 16'h2010, 16'hBEEF, 1, 1, "R8");
    acc(0, 16'h0102, 0, 0, 0, "R5");
    // R6 timeout boundary
    acc(1, 16'h0104, 16'h0001, 0, 0, "R6");
    acc(0, 16'h3000, 0, 1, 0, "R6"); acc(0, 16'h3000, 0, 1, 512, "R6");
    acc(1, 16'h3002, 16'h1, 1, 0, "R6"); acc(0, 16'h0102, 0, 0, 0, "R6");
    // R7 enable off: forwarded, times out as a timeout not an invalid access
    acc(1, 16'h0100, 16'h0000, 0, 0, "R7");
    acc(0, 16'h0200, 0, 0, 0, "R7"); acc(0, 16'h0102, 0, 0, 0, "R7");
    acc(1, 16'h0104, 16'h0000, 0, 0, "R7");
    acc(0, 16'h0200, 0, 0, 0, "R7");
    do_reset();
    // R9 idle
    begin
      int n = 0; bit bad = 0;
      @(negedge clk);
      idle = 1; req_valid = 1; req_write = 0; req_addr = 16'h0100;
      repeat (30) begin @(negedge clk); if (rsp_valid || per_req) bad = 1; end
      chk(!bad, "R9", "activity while idle", int'(bad), 0);
      idle = 0;
      while (!rsp_valid && n < 10) begin @(negedge clk); n++; end
      chk(n == 1 && rsp_rdata == 16'h8000, "R9", "served after idle", n, 1);
      req_valid = 0;
    end
    // random mix
    for (int i = 0; i < 300; i++) begin
      int k = $urandom % 10;
      logic [15:0] a;
      int dly = 1 + $urandom % 8;
      bit w = $urandom % 2;
      if (k < 4) a = (($urandom % 3 == 0) ? 16'h0000 : ($urandom % 2) ? 16'h1400 : 16'h2000) + 16'($urandom % 1024);
      else if (k < 7) a = 16'h0400 + 16'($urandom % 16'h1000);
      else if (k < 9) a = 16'h0102;
      else a = ($urandom % 2) ? 16'h0100 : 16'h0104;
      if (a == 16'h0100 && w) begin acc(1, a, ($urandom % 4 == 0) ? 16'h0 : 16'h8000, 0, 0, "R3"); continue; end
      if (a == 16'h0104 && w) begin acc(1, a, 16'($urandom % 2), 0, 0, "R3"); continue; end
      if (m_to && $urandom % 25 == 0) dly = 0;
      acc(w, a, 16'($urandom), $urandom % 2, dly, "R8");
    end
    summary();
    $finish;
  end
endmodule